// File: doc/BRIEF.md
# I2C Register Write Slave

This block is the write-only I2C target front end of a larger controller. It watches the SCL and SDA lines with a fast system clock and finds START and STOP conditions. It accepts a write transaction addressed to its own 7-bit device address, which is a fixed six-bit prefix followed by one strap-pin bit. It acknowledges each accepted byte by pulling SDA low during the ninth clock pulse.

The first byte after the address is a register pointer. Every byte after that is written into a bank of 8-bit configuration registers at the pointer, and the pointer then advances. A host can therefore fill a run of registers in one burst. The rest of the controller sees all the registers at once on a flat, read-only parallel output.

The system clock must run at least 16 times faster than SCL, so Standard and Fast mode buses are covered.

Top module: `i2cw_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state, including in the middle of a byte, clears the bit count and begins a new address phase. A STOP (SDA rising while SCL is high) returns the receiver to idle with SDA released.
- R2: An address byte equal to {6'b100100, strap_i, 1'b0} (address MSB first, R/W bit last with 0 = write) is acknowledged. The acknowledge is `sda_oe` = 1, which pulls SDA low during the ninth SCL pulse.
- R3: An address byte that does not match, or that has R/W = 1, gets no acknowledge. Every later byte is then ignored, with no acknowledge and no register change, until the next START.
- R4: The byte after a matched address loads bits 5:0 into the register pointer and is acknowledged. If its bits 7:6 are not both zero, it gets no acknowledge and the bus is ignored until the next START.
- R5: Each following data byte, received MSB first, is written to the register selected by the pointer and is acknowledged.
- R6: After each data byte the pointer increments by one, so consecutive data bytes land in consecutive registers.
- R7: A data byte written at pointer 1FH moves the pointer to 00H. Later bytes in the same burst overwrite registers from 00H upward.
- R8: After reset all 32 registers read zero. A STOP, or a START followed by a STOP, leaves the register contents unchanged.
- R9: `sda_oe` changes only while SCL is low. It is released once the ninth SCL pulse has ended.
- R10: While the pointer holds 20H to 3FH, data bytes are acknowledged but discarded, and the pointer still counts. From 3FH it steps to 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level as seen on the wired bus |
| strap_i | input | 1 | Strap pin giving the lowest device address bit |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| regs_o | output | 256 | All registers, register n at bits [8n+7:8n] |

## Verification
Some properties are checked on every cycle. The acknowledge drive only ever switches while SCL is low. A STOP always releases SDA and idles the receiver. A START always restarts the bit count. The skip state never drives SDA or writes. Writes only ever reach indices inside the bank, and a write at 1FH leaves the pointer at zero. The registers hold whenever no write strobe is present.

Other behaviour can only be shown by the bench's transactions. This covers which byte values are acknowledged and which data ends up in which register. It also covers bursts across the wrap and out-of-range pointers. Finally, it covers what survives a repeated START in the middle of a byte, a rejected address and a rejected pointer byte.

// File: rtl/i2cw_pkg.sv
// Shared types for the I2C register write slave.
package i2cw_pkg;
    // Receiver phases: waiting, device address, register pointer, data, ignoring bus.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_DATA,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2cw_sync.sv
// Two-flop synchronizer plus edge detector for a group of slow bus lines.
// Assumes the lines idle high and change far slower than clk.
module i2cw_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic s1, s2, s3;
            // Synchronize the line and keep one older sample for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b1;
                    s2 <= 1'b1;
                    s3 <= 1'b1;
                end else begin
                    s1 <= din[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign lvl[g]  = s2;
            assign rise[g] = s2 & ~s3;
            assign fall[g] = ~s2 & s3;
        end
    endgenerate
endmodule

// File: rtl/i2cw_rx.sv
// Byte receiver and protocol state machine for write-only I2C transfers.
// Works on synchronized SCL/SDA levels and edges. It matches the device
// address, loads the register pointer, issues write strobes and drives ACK.
// Assumes 1 <= PTR_W <= 7 and NREG <= 2**PTR_W.
module i2cw_rx
    import i2cw_pkg::*;
#(
    parameter logic [5:0] DEV_PREFIX = 6'b100100,
    parameter int         PTR_W      = 6,
    parameter int         NREG       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic             strap,
    output logic             sda_oe,
    output logic             we,
    output logic [PTR_W-1:0] waddr,
    output logic [7:0]       wdata
);
    localparam logic [PTR_W-1:0] LAST   = PTR_W'(NREG - 1);
    localparam logic [PTR_W:0]   NREG_W = (PTR_W + 1)'(NREG);

    rx_state_t        state;
    logic [3:0]       bcnt;
    logic [7:0]       shreg;
    logic [PTR_W-1:0] ptr, ptr_next;
    logic             start, stop;

    assign start = sda_fall & scl_lvl;
    assign stop  = sda_rise & scl_lvl;

    // Next pointer: wrap after the last register, otherwise count freely.
    always_comb begin
        if (ptr == LAST) ptr_next = '0;
        else             ptr_next = ptr + 1'b1;
    end

    // Protocol sequencing: bit shifting, byte decisions, ACK drive, writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bcnt   <= '0;
            shreg  <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
            we     <= 1'b0;
            waddr  <= '0;
            wdata  <= '0;
        end else begin
            we <= 1'b0;
            if (start) begin
                state  <= ST_ADDR;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (stop) begin
                state  <= ST_IDLE;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (state == ST_ADDR || state == ST_REG || state == ST_DATA) begin
                if (scl_rise) begin
                    if (bcnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
                    if (bcnt < 4'd9) bcnt <= bcnt + 4'd1;
                end else if (scl_fall) begin
                    if (bcnt == 4'd8) begin
                        case (state)
                            ST_ADDR: begin
                                if (shreg == {DEV_PREFIX, strap, 1'b0}) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_REG;
                                end else begin
                                    state  <= ST_SKIP;
                                end
                            end
                            ST_REG: begin
                                if (shreg[7:PTR_W] == '0) begin
                                    ptr    <= shreg[PTR_W-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_DATA;
                                end else begin
                                    state  <= ST_SKIP;
                                end
                            end
                            default: begin
                                sda_oe <= 1'b1;
                                we     <= ({1'b0, ptr} < NREG_W);
                                waddr  <= ptr;
                                wdata  <= shreg;
                                ptr    <= ptr_next;
                            end
                        endcase
                    end else if (bcnt == 4'd9) begin
                        sda_oe <= 1'b0;
                        bcnt   <= '0;
                    end
                end
            end
        end
    end

    // R9: the ACK drive toggles only while SCL is low.
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_lvl);
    // R1: STOP idles the receiver and releases SDA.
    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (state == ST_IDLE && !sda_oe));
    // R1: START restarts the address phase with a cleared bit count.
    p_start_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_ADDR && bcnt == 4'd0));
    // R3: while ignoring the bus, nothing is driven or written.
    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe && !we));
    // R7: a write at the last register leaves the pointer at zero.
    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == LAST) |-> (ptr == '0));
endmodule

// File: rtl/i2cw_regfile.sv
// Bank of 8-bit registers with one write port and all contents exposed flat.
// Assumes waddr is below NREG whenever we is high.
module i2cw_regfile #(
    parameter int NREG  = 32,
    parameter int PTR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [7:0]        wdata,
    output logic [NREG*8-1:0] rdata
);
    localparam logic [PTR_W:0] NREG_W = (PTR_W + 1)'(NREG);

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            // Hold one register; load it when the write strobe selects it.
            always_ff @(posedge clk) begin
                if (!rst_n)                             rdata[i*8 +: 8] <= 8'h00;
                else if (we && waddr == PTR_W'(i))      rdata[i*8 +: 8] <= wdata;
            end
        end
    endgenerate

    // R10: write strobes only ever target an existing register.
    p_we_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < NREG_W));
    // R8: contents hold whenever no write is issued.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/i2cw_slave.sv
// Top of the write-only I2C register slave: synchronizer, receiver, registers.
// Assumes clk runs at 16x the SCL rate or faster. sda_oe drives an external
// open-drain pull-down.
module i2cw_slave #(
    parameter logic [5:0] DEV_PREFIX = 6'b100100,
    parameter int         PTR_W      = 6,
    parameter int         NREG       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    logic [1:0]       lvl, rise, fall;
    logic             we;
    logic [PTR_W-1:0] waddr;
    logic [7:0]       wdata;

    i2cw_sync #(.LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    i2cw_rx #(.DEV_PREFIX(DEV_PREFIX), .PTR_W(PTR_W), .NREG(NREG)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (lvl[1]),
        .scl_rise(rise[1]),
        .scl_fall(fall[1]),
        .sda_lvl (lvl[0]),
        .sda_rise(rise[0]),
        .sda_fall(fall[0]),
        .strap   (strap_i),
        .sda_oe  (sda_oe),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata)
    );

    i2cw_regfile #(.NREG(NREG), .PTR_W(PTR_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .rdata(regs_o)
    );
endmodule

// File: tb/i2cw_slave_test.sv
// Directed bench for the I2C register write slave. Each scenario is one
// task that checks its own results.
module i2cw_slave_test;
    localparam int Q = 8;   // clk cycles per quarter SCL period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_m = 1'b1;
    logic         strap = 1'b1;
    logic         sda_oe;
    logic [255:0] regs;
    logic         bus_sda;
    int           ntot = 0;
    int           nbad = 0;

    assign bus_sda = sda_m & ~sda_oe;
    always #2 clk = ~clk;

    i2cw_slave uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (bus_sda),
        .strap_i(strap),
        .sda_oe (sda_oe),
        .regs_o (regs)
    );

    function automatic logic [7:0] rg(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl = 1'b1;   w(Q);
        sda_m = 1'b0; w(Q);
        scl = 1'b0;   w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl = 1'b1;   w(Q);
        sda_m = 1'b1; w(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; w(Q);
            scl = 1'b1;   w(2*Q);
            scl = 1'b0;   w(Q);
        end
    endtask

    // Send a byte, return the ACK seen during pulse nine, check the release (R9).
    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; w(Q);
        scl = 1'b1;   w(Q);
        ack = ~bus_sda; w(Q);
        scl = 1'b0;   w(Q);
        chk("R9 sda released after ninth pulse", sda_oe, 1'b0);
    endtask

    task automatic t_reset();
        chk("R8 sda_oe idle after reset", sda_oe, 1'b0);
        for (int i = 0; i < 32; i++) chk("R8 register zero after reset", rg(i), 8'h00);
    endtask

    task automatic t_single();
        logic a;
        bus_start();
        send_byte(8'h92, a); chk("R2 address ack", a, 1'b1);
        send_byte(8'h05, a); chk("R4 pointer ack", a, 1'b1);
        send_byte(8'hA5, a); chk("R5 data ack", a, 1'b1);
        bus_stop();
        chk("R5 reg05 written", rg(5), 8'hA5);
        chk("R5 reg04 untouched", rg(4), 8'h00);
    endtask

    task automatic t_burst();
        logic a;
        bus_start();
        send_byte(8'h92, a);
        send_byte(8'h10, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a); chk("R6 burst ack", a, 1'b1);
        bus_stop();
        chk("R6 reg10", rg(16), 8'h11);
        chk("R6 reg11", rg(17), 8'h22);
        chk("R6 reg12", rg(18), 8'h33);
    endtask

    task automatic t_wrap();
        logic a;
        bus_start();
        send_byte(8'h92, a);
        send_byte(8'h1E, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h03, a); chk("R7 wrapped byte ack", a, 1'b1);
        bus_stop();
        chk("R7 reg1E", rg(30), 8'h01);
        chk("R7 reg1F", rg(31), 8'h02);
        chk("R7 reg00 overwritten after wrap", rg(0), 8'h03);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'h90, a); chk("R3 wrong strap bit no ack", a, 1'b0);
        send_byte(8'h02, a); chk("R3 later byte no ack", a, 1'b0);
        send_byte(8'h77, a);
        bus_stop();
        chk("R3 reg02 unchanged after mismatch", rg(2), 8'h00);
        bus_start();
        send_byte(8'h93, a); chk("R3 read bit no ack", a, 1'b0);
        send_byte(8'h02, a);
        send_byte(8'h66, a); chk("R3 data after read no ack", a, 1'b0);
        bus_stop();
        chk("R3 reg02 unchanged after read request", rg(2), 8'h00);
    endtask

    task automatic t_bad_reg();
        logic a;
        bus_start();
        send_byte(8'h92, a);
        send_byte(8'h45, a); chk("R4 pointer with high bits no ack", a, 1'b0);
        send_byte(8'h99, a); chk("R4 data after bad pointer no ack", a, 1'b0);
        bus_stop();
        chk("R4 reg05 kept", rg(5), 8'hA5);
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'h92, a);
        send_byte(8'h08, a);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'h92, a); chk("R1 address ack after mid-byte restart", a, 1'b1);
        send_byte(8'h09, a);
        send_byte(8'hC3, a);
        bus_stop();
        chk("R1 reg08 untouched by cut byte", rg(8), 8'h00);
        chk("R1 reg09 written after restart", rg(9), 8'hC3);
    endtask

    task automatic t_stop_keep();
        bus_start();
        bus_stop();
        chk("R8 reg05 kept over empty transfer", rg(5), 8'hA5);
        chk("R8 reg1F kept over empty transfer", rg(31), 8'h02);
        chk("R1 idle bus not driven", sda_oe, 1'b0);
    endtask

    task automatic t_high_ptr();
        logic a;
        bus_start();
        send_byte(8'h92, a);
        send_byte(8'h3F, a); chk("R10 pointer 3F ack", a, 1'b1);
        send_byte(8'hEE, a); chk("R10 out-of-range data ack", a, 1'b1);
        send_byte(8'h44, a);
        bus_stop();
        chk("R10 reg00 written after 3F wraps", rg(0), 8'h44);
        chk("R10 reg1F not hit by discarded byte", rg(31), 8'h02);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        ntot++;
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        w(4);
        rst_n = 1'b1;
        w(4);
        t_reset();
        t_single();
        t_burst();
        t_wrap();
        t_bad_addr();
        t_bad_reg();
        t_restart();
        t_stop_keep();
        t_high_ptr();
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule